// File: doc/BRIEF.md
# MSI Directory Home Controller

This block is the memory-side home node of a two-level coherence system. It stores backing data for a small address space. For every child cache and every address it tracks an MSI state and a flag that marks an outstanding downgrade request. Children send upgrade requests on one request channel and send downgrade or eviction responses on a separate response channel. The block answers on a single outgoing message port. Each message is either a grant, which may carry data, or a downgrade request aimed at one child.

A request from child `c` for state `y` is granted only when two conditions hold: every other child holds a state compatible with `y`, and no downgrade to `c` is pending for that address. The pairings M/M, M/S and S/M are incompatible; every other pairing is compatible. While the request is blocked, the block sends a downgrade request to one incompatible child per cycle and skips children it is already waiting on. A response updates the responding child's state and clears its wait flag. If that child held M, the response also writes its data back to memory. Voluntary evictions use the same response path. A response always takes the cycle in preference to the request at the head of the request channel.

Top module: `msi_home`

## Requirements
- R1: After reset every child is in I for every address, no wait flag is set, memory word `a` holds `INIT_BASE + a`, and `out_valid` is low.
- R2: A head request (child `c`, address `a`, wanted state `y`) is accepted with `req_ready` high in the same cycle when no other child holds an incompatible state and `c` has no pending downgrade. The grant appears on the next cycle with `out_dgrade`=0, the requesting child, the address and `out_state`=`y`. State codes are I=0, S=1, M=2. Incompatible pairs are M/M, M/S and S/M.
- R3: A grant carries `out_has_data`=1 and the memory word only when the requester was in I. Otherwise `out_has_data`=0 and `out_data`=0. Downgrade requests never carry data.
- R4: While the head request is blocked, the block sends a downgrade request (`out_dgrade`=1) to the lowest-numbered other child that is incompatible and not awaited. The target state is I when `y` is M and S otherwise.
- R5: A child with a pending downgrade for the address receives no further downgrade for it. When every blocker is already awaited, no message is sent and `req_ready` stays low.
- R6: A request from a child that itself has a pending downgrade for the address is not granted, even when all other children are compatible.
- R7: A response sets the child's state to the reported value and clears its wait flag. The response data is written to memory only if the child was in M; otherwise the data is ignored.
- R8: An unsolicited response, such as an eviction from M to I, is handled exactly as in R7. Afterwards a request that needs that address is granted without any downgrade.
- R9: In a cycle with `rsp_valid` high, the head request is not processed: `req_ready` is low and no message is sent on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Head request present |
| req_child | input | CW | Requesting child |
| req_addr | input | AW | Requested address |
| req_want | input | 2 | Wanted state (S=1, M=2) |
| req_ready | output | 1 | Head request granted and consumed this cycle |
| rsp_valid | input | 1 | Response present (always consumed) |
| rsp_child | input | CW | Responding child |
| rsp_addr | input | AW | Response address |
| rsp_state | input | 2 | State the child now holds |
| rsp_data | input | DATA_W | Write-back data |
| out_valid | output | 1 | Outgoing message valid |
| out_dgrade | output | 1 | 1 = downgrade request, 0 = grant |
| out_child | output | CW | Destination child |
| out_addr | output | AW | Message address |
| out_state | output | 2 | Granted or target state |
| out_has_data | output | 1 | Message carries data |
| out_data | output | DATA_W | Data for a grant from I |

## Verification
The hardest situation to reach is a request from a child that already has a downgrade pending against it (R6). In that case the only reason to withhold the grant is the wait flag, since every other child is compatible. To build it, the stimulus leaves one child in M and lets a second child's S request trigger a downgrade to the owner. It then swaps the head of the request channel to the owner's own M request before the owner responds. The owner's later response proves the stall was caused only by the flag: its write-back data arrives at the next I-state reader.

// File: rtl/msi_home.sv
module msi_home #(
  parameter int N_CHILD   = 4,
  parameter int N_ADDR    = 8,
  parameter int DATA_W    = 8,
  parameter int INIT_BASE = 160,
  localparam int CW = (N_CHILD > 1) ? $clog2(N_CHILD) : 1,
  localparam int AW = (N_ADDR > 1) ? $clog2(N_ADDR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CW-1:0]     req_child,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_want,
  output logic              req_ready,
  input  logic              rsp_valid,
  input  logic [CW-1:0]     rsp_child,
  input  logic [AW-1:0]     rsp_addr,
  input  logic [1:0]        rsp_state,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              out_valid,
  output logic              out_dgrade,
  output logic [CW-1:0]     out_child,
  output logic [AW-1:0]     out_addr,
  output logic [1:0]        out_state,
  output logic              out_has_data,
  output logic [DATA_W-1:0] out_data
);
  localparam logic [1:0] ST_I = 2'd0;
  localparam logic [1:0] ST_S = 2'd1;
  localparam logic [1:0] ST_M = 2'd2;

  logic [1:0]        st_q   [N_CHILD][N_ADDR];
  logic [N_ADDR-1:0] wait_q [N_CHILD];
  logic [DATA_W-1:0] mem_q  [N_ADDR];

  function automatic logic clash(input logic [1:0] a, input logic [1:0] b);
    return (a == ST_M && b != ST_I) || (b == ST_M && a != ST_I);
  endfunction

  logic [N_CHILD-1:0] blocker, sendable;
  logic               self_wait, have_pick, grant;
  logic [CW-1:0]      pick;
  logic [1:0]         req_cur;

  always_comb begin
    for (int i = 0; i < N_CHILD; i++) begin
      blocker[i]  = (CW'(i) != req_child) && clash(st_q[i][req_addr], req_want);
      sendable[i] = blocker[i] && !wait_q[i][req_addr];
    end
    have_pick = 1'b0;
    pick      = '0;
    for (int i = N_CHILD - 1; i >= 0; i--) begin
      if (sendable[i]) begin
        have_pick = 1'b1;
        pick      = CW'(i);
      end
    end
  end

  assign self_wait = wait_q[req_child][req_addr];
  assign req_cur   = st_q[req_child][req_addr];
  assign grant     = req_valid && !rsp_valid && (blocker == '0) && !self_wait;
  assign req_ready = grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CHILD; i++) begin
        wait_q[i] <= '0;
        for (int a = 0; a < N_ADDR; a++) st_q[i][a] <= ST_I;
      end
      for (int a = 0; a < N_ADDR; a++) mem_q[a] <= DATA_W'(INIT_BASE + a);
      out_valid    <= 1'b0;
      out_dgrade   <= 1'b0;
      out_child    <= '0;
      out_addr     <= '0;
      out_state    <= ST_I;
      out_has_data <= 1'b0;
      out_data     <= '0;
    end else begin
      out_valid <= 1'b0;
      if (rsp_valid) begin
        if (st_q[rsp_child][rsp_addr] == ST_M) mem_q[rsp_addr] <= rsp_data;
        st_q[rsp_child][rsp_addr]   <= rsp_state;
        wait_q[rsp_child][rsp_addr] <= 1'b0;
      end else if (grant) begin
        out_valid    <= 1'b1;
        out_dgrade   <= 1'b0;
        out_child    <= req_child;
        out_addr     <= req_addr;
        out_state    <= req_want;
        out_has_data <= (req_cur == ST_I);
        out_data     <= (req_cur == ST_I) ? mem_q[req_addr] : '0;
        st_q[req_child][req_addr] <= req_want;
      end else if (req_valid && have_pick) begin
        out_valid    <= 1'b1;
        out_dgrade   <= 1'b1;
        out_child    <= pick;
        out_addr     <= req_addr;
        out_state    <= (req_want == ST_M) ? ST_I : ST_S;
        out_has_data <= 1'b0;
        out_data     <= '0;
        wait_q[pick][req_addr] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/msi_home_chk.sv
module msi_home_chk #(
  parameter int N_CHILD   = 4,
  parameter int N_ADDR    = 8,
  parameter int DATA_W    = 8,
  parameter int INIT_BASE = 160,
  localparam int CW = (N_CHILD > 1) ? $clog2(N_CHILD) : 1,
  localparam int AW = (N_ADDR > 1) ? $clog2(N_ADDR) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [CW-1:0]     req_child,
  input logic [AW-1:0]     req_addr,
  input logic [1:0]        req_want,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [CW-1:0]     rsp_child,
  input logic [AW-1:0]     rsp_addr,
  input logic [1:0]        rsp_state,
  input logic [DATA_W-1:0] rsp_data,
  input logic              out_valid,
  input logic              out_dgrade,
  input logic [CW-1:0]     out_child,
  input logic [AW-1:0]     out_addr,
  input logic [1:0]        out_state,
  input logic              out_has_data,
  input logic [DATA_W-1:0] out_data
);
  a_r9_rsp_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  a_r9_rsp_no_msg: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !out_valid);
  a_r2_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);
  a_r2_grant_msg: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> out_valid && !out_dgrade && out_child == $past(req_child)
                  && out_addr == $past(req_addr) && out_state == $past(req_want));
  a_r4_dg_target: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dgrade) |-> out_child != $past(req_child) && out_addr == $past(req_addr)
                  && out_state == (($past(req_want) == 2'd2) ? 2'd0 : 2'd1));
  a_r3_dg_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dgrade) |-> !out_has_data);
endmodule

bind msi_home msi_home_chk #(
  .N_CHILD(N_CHILD), .N_ADDR(N_ADDR), .DATA_W(DATA_W), .INIT_BASE(INIT_BASE)
) u_chk (.*);

// File: tb/msi_home_bench.sv
module msi_home_bench;
  localparam int CW = 2, AW = 3, DW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, rsp_valid = 0;
  logic [CW-1:0] req_child = 0, rsp_child = 0, out_child;
  logic [AW-1:0] req_addr = 0, rsp_addr = 0, out_addr;
  logic [1:0] req_want = 0, rsp_state = 0, out_state;
  logic [DW-1:0] rsp_data = 0, out_data;
  logic req_ready, out_valid, out_dgrade, out_has_data;
  int n_run = 0, n_fail = 0;
  logic g_rdy;

  always #5 clk = ~clk;

  msi_home u_msi_home (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic send_req(input int c, input int a, input int w);
    req_valid = 1; req_child = CW'(c); req_addr = AW'(a); req_want = 2'(w);
    #1 g_rdy = req_ready;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic send_rsp(input int c, input int a, input int s, input int d);
    rsp_valid = 1; rsp_child = CW'(c); rsp_addr = AW'(a); rsp_state = 2'(s); rsp_data = DW'(d);
    @(posedge clk); #1;
    rsp_valid = 0;
  endtask

  task automatic expect_grant(input string tag, input int c, input int a, input int s,
                              input int hd, input int d);
    chk({tag, " ready"}, g_rdy, 1);
    chk({tag, " msg"}, {out_valid, out_dgrade, 2'(out_child), 3'(out_addr), out_state},
        {1'b1, 1'b0, 2'(c), 3'(a), 2'(s)});
    chk({tag, " data"}, {out_has_data, out_data}, {1'(hd), 8'(d)});
  endtask

  task automatic expect_dg(input string tag, input int c, input int s);
    chk({tag, " ready"}, g_rdy, 0);
    chk({tag, " msg"}, {out_valid, out_dgrade, 2'(out_child), out_state, out_has_data},
        {1'b1, 1'b1, 2'(c), 2'(s), 1'b0});
  endtask

  task automatic expect_idle(input string tag);
    chk({tag, " ready"}, g_rdy, 0);
    chk({tag, " valid"}, out_valid, 0);
  endtask

  task automatic t_reset;
    #1 chk("R1 out_valid", out_valid, 0);
    send_req(0, 6, 1);
    expect_grant("R1 init data", 0, 6, 1, 1, 160 + 6);
  endtask

  task automatic t_share;
    send_req(0, 1, 1); expect_grant("R2 first S", 0, 1, 1, 1, 161);
    send_req(1, 1, 1); expect_grant("R2 S with S R3", 1, 1, 1, 1, 161);
  endtask

  task automatic t_invalidate;
    send_req(2, 1, 2); expect_dg("R4 first blocker", 0, 0);
    send_req(2, 1, 2); expect_dg("R4 next blocker R5", 1, 0);
    send_req(2, 1, 2); expect_idle("R5 all awaited");
    send_rsp(0, 1, 0, 8'h55);
    send_rsp(1, 1, 0, 8'h66);
    send_req(2, 1, 2); expect_grant("R7 S data ignored", 2, 1, 2, 1, 161);
  endtask

  task automatic t_self_wait;
    send_req(0, 1, 1); expect_dg("R4 M to S", 2, 1);
    send_req(2, 1, 2); expect_idle("R6 self pending");
    send_rsp(2, 1, 1, 8'h77);
    send_req(0, 1, 1); expect_grant("R7 M writeback", 0, 1, 1, 1, 8'h77);
  endtask

  task automatic t_upgrade_nodata;
    send_req(2, 1, 2); expect_dg("R4 S to I", 0, 0);
    send_rsp(0, 1, 0, 8'h11);
    send_req(2, 1, 2); expect_grant("R3 no data from S", 2, 1, 2, 0, 0);
  endtask

  task automatic t_evict;
    send_rsp(2, 1, 0, 8'h3C);
    send_req(1, 1, 2); expect_grant("R8 after eviction", 1, 1, 2, 1, 8'h3C);
  endtask

  task automatic t_priority;
    req_valid = 1; req_child = 0; req_addr = 2; req_want = 1;
    rsp_valid = 1; rsp_child = 3; rsp_addr = 5; rsp_state = 0; rsp_data = 8'hEE;
    #1 chk("R9 ready low", req_ready, 0);
    @(posedge clk); #1;
    rsp_valid = 0; req_valid = 0;
    chk("R9 no msg", out_valid, 0);
    send_req(0, 2, 1); expect_grant("R9 later grant", 0, 2, 1, 1, 162);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_share;
    t_invalidate;
    t_self_wait;
    t_upgrade_nodata;
    t_evict;
    t_priority;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule